// File: doc/BRIEF.md
# Flash Program Buffer Sequencer

This block sits behind a register decoder and turns decoded register writes into timed flash operations on a behavioural non-volatile array. Software sets a byte address, clears the fill index, and pushes bytes through a data port. Each accepted byte lands in the 32-byte row buffer at the lane that the low address bits plus the current index select, and the index then steps by one. A command write then starts a program, page erase or whole-array erase. Busy stays high from the cycle after the command until the operation has run to its end.

Every operation runs as four phases. A fixed setup phase comes first. The main phase follows, with its length taken from the program or erase timing field. Then comes a hold phase of the hold-time field, and the block returns to idle. The array changes at the last cycle of the main phase. When a program finishes, the address register moves forward by the fill index, so a long transfer needs only one address write followed by one refill per row. The array can be read a byte at a time through a combinational read port.

Top module: `flash_pgm_seq`

## Requirements
- R1: An accepted data write stores the byte at row lane (address[4:0] + index) and raises the index by one.
- R2: An index write loads the written value; writing 0 clears the index.
- R3: A data write whose lane (address[4:0] + index) would be 32 or more is dropped: nothing is stored and the index does not move, so one fill never crosses a 32-byte row.
- R4: A program touches only the lanes address[4:0] up to address[4:0]+index-1 of the row that address[12:5] selects. Each such byte becomes old AND buffered, so bits can only be cleared. Every other byte keeps its value.
- R5: When a program completes, the address register grows by the index value. An erase leaves the address unchanged.
- R6: Busy is high for exactly 2 + max(1, Tmain) + max(1, Thold) cycles, starting the cycle after the command. Tmain is timing write select 2 data[15:0] for a program and select 1 data[23:0] for an erase. Thold is select 0 data[31:16].
- R7: Command bit 1 requests an erase and takes precedence over bit 0 (program). With bit 2 also set, the 4096-byte page that address[12] selects is set to 0xFF. Without bit 2, the whole array is set to 0xFF. A command with bits 0 and 1 both clear starts nothing.
- R8: While busy is high, writes to the command, address, index, data and timing inputs are ignored.
- R9: After reset, busy is 0, the address is 0, the index is 0, every timing field is 0 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr | input | 1 | Address register write strobe |
| addr_wdata | input | 13 | New byte address |
| idx_wr | input | 1 | Fill index write strobe |
| idx_wdata | input | 6 | New fill index |
| data_wr | input | 1 | Buffer data port write strobe |
| data_wdata | input | 8 | Byte for the row buffer |
| tim_wr_sel | input | 3 | Timing write select: bit 0 hold, bit 1 erase, bit 2 program |
| tim_wdata | input | 32 | Timing write data |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 3 | Command: bit 0 program, bit 1 erase, bit 2 page select |
| busy | output | 1 | Operation in progress |
| addr_q | output | 13 | Current address register |
| idx_q | output | 6 | Current fill index |
| rd_addr | input | 13 | Array read byte address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The assertions assume that the decoder raises each write strobe for single cycles, with data valid in the same cycle. They also assume that software does not move the address between filling the buffer and issuing the program, since the lane mask is formed from the live address. The bench changes inputs only on falling edges and holds each strobe for one cycle. It refills the buffer after every address change and before each program, and it writes during busy only in the one scenario that checks those writes are dropped.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;

  typedef enum logic [1:0] {
    OP_NONE       = 2'd0,
    OP_PROG       = 2'd1,
    OP_PAGE_ERASE = 2'd2,
    OP_MASS_ERASE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_MAIN  = 2'd2,
    PH_HOLD  = 2'd3
  } phase_e;

  localparam int CMD_PROG_BIT  = 0;
  localparam int CMD_ERASE_BIT = 1;
  localparam int CMD_PAGE_BIT  = 2;
  localparam int MAX_LANES     = 64;

  // Erase outranks program; page select only qualifies erase.
  function automatic op_e decode_cmd(input logic [2:0] c);
    if (c[CMD_ERASE_BIT])
      return c[CMD_PAGE_BIT] ? OP_PAGE_ERASE : OP_MASS_ERASE;
    else if (c[CMD_PROG_BIT])
      return OP_PROG;
    else
      return OP_NONE;
  endfunction

  // A zero timing field still gives a one-cycle phase.
  function automatic logic [23:0] phase_len(input logic [23:0] t);
    return (t == 24'd0) ? 24'd1 : t;
  endfunction

  // Lanes lo .. lo+cnt-1 are set.
  function automatic logic [MAX_LANES-1:0] lane_mask(input int lo, input int cnt);
    logic [MAX_LANES-1:0] m;
    for (int l = 0; l < MAX_LANES; l++)
      m[l] = (l >= lo) && (l < lo + cnt);
    return m;
  endfunction

endpackage

// File: rtl/pgm_buffer.sv
module pgm_buffer
  import flash_pgm_pkg::*;
#(
  parameter int ROW_BYTES = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      data_we,
  input  logic [7:0]                data_in,
  input  logic                      idx_we,
  input  logic [$clog2(ROW_BYTES):0] idx_in,
  input  logic [$clog2(ROW_BYTES)-1:0] row_off,
  output logic [$clog2(ROW_BYTES):0] idx_q,
  output logic [ROW_BYTES*8-1:0]    row_data,
  output logic [ROW_BYTES-1:0]      row_mask,
  output logic                      data_taken
);
  localparam int LANE_W = $clog2(ROW_BYTES);
  localparam int IDX_W  = LANE_W + 1;

  logic [7:0]           bytes_q [ROW_BYTES];
  logic [IDX_W:0]       lane_sum;
  logic [MAX_LANES-1:0] full_mask;

  assign lane_sum   = (IDX_W+1)'(row_off) + (IDX_W+1)'(idx_q);
  assign data_taken = data_we && (lane_sum < (IDX_W+1)'(ROW_BYTES));
  assign full_mask  = lane_mask(int'(row_off), int'(idx_q));
  assign row_mask   = full_mask[ROW_BYTES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < ROW_BYTES; i++) bytes_q[i] <= 8'hFF;
    end else begin
      if (data_taken) bytes_q[lane_sum[LANE_W-1:0]] <= data_in;
      if (idx_we)          idx_q <= idx_in;
      else if (data_taken) idx_q <= idx_q + IDX_W'(1);
    end
  end

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_flat
    assign row_data[g*8 +: 8] = bytes_q[g];
  end

  // R1: an accepted byte steps the index by one
  a_r1_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_taken && !idx_we) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

  // R2: writing zero clears the index
  a_r2_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_we && idx_in == '0) |=> (idx_q == '0));

  // R3: an accepted byte never lands beyond the row
  a_r3_lane_in_row: assert property (@(posedge clk) disable iff (!rst_n)
    data_taken |-> (int'(row_off) + int'(idx_q) < ROW_BYTES));

endmodule

// File: rtl/op_sequencer.sv
module op_sequencer
  import flash_pgm_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int SETUP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] main_len,
  input  logic [CNT_W-1:0] hold_len,
  output logic             busy,
  output logic             main_done,
  output logic             op_done
);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero  = (cnt_q == '0);
  assign busy      = (phase_q != PH_IDLE);
  assign main_done = (phase_q == PH_MAIN) && cnt_zero;
  assign op_done   = (phase_q == PH_HOLD) && cnt_zero;

  // One down-counter serves all phases; each reload is length-1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_SETUP;
          cnt_q   <= SETUP_LAST;
        end
        PH_SETUP: if (cnt_zero) begin
          phase_q <= PH_MAIN;
          cnt_q   <= main_len - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_MAIN: if (cnt_zero) begin
          phase_q <= PH_HOLD;
          cnt_q   <= hold_len - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_HOLD: if (cnt_zero) begin
          phase_q <= PH_IDLE;
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R6: busy only ends from the last hold cycle
  a_r6_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(op_done));

  // R8: the parent never starts an operation while one runs
  a_r8_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R6: a started operation is busy on the next cycle
  a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

endmodule

// File: rtl/nvm_array_model.sv
module nvm_array_model
  import flash_pgm_pkg::*;
#(
  parameter int NUM_PAGES  = 2,
  parameter int PAGE_BYTES = 4096,
  parameter int ROW_BYTES  = 32
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        prog_en,
  input  logic                                        erase_page_en,
  input  logic                                        erase_all_en,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES/ROW_BYTES)-1:0] row_sel,
  input  logic [$clog2(NUM_PAGES)-1:0]                page_sel,
  input  logic [ROW_BYTES*8-1:0]                      prog_data,
  input  logic [ROW_BYTES-1:0]                        prog_mask,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0]     rd_addr,
  output logic [7:0]                                  rd_data
);
  localparam int ROW_BITS      = ROW_BYTES * 8;
  localparam int NUM_ROWS      = NUM_PAGES * PAGE_BYTES / ROW_BYTES;
  localparam int ROWS_PER_PAGE = PAGE_BYTES / ROW_BYTES;
  localparam int ADDR_W        = $clog2(NUM_PAGES * PAGE_BYTES);
  localparam int LANE_W        = $clog2(ROW_BYTES);

  logic [ROW_BITS-1:0] mem [NUM_ROWS];
  logic [ROW_BITS-1:0] cur_row, new_row, rd_row;

  assign cur_row = mem[row_sel];
  assign rd_row  = mem[rd_addr[ADDR_W-1:LANE_W]];
  assign rd_data = rd_row[{rd_addr[LANE_W-1:0], 3'b000} +: 8];

  // Per-lane merge: programming can only pull bits to zero.
  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
    assign new_row[g*8 +: 8] = prog_mask[g] ? (cur_row[g*8 +: 8] & prog_data[g*8 +: 8])
                                            : cur_row[g*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_ROWS; r++) mem[r] <= '1;
    end else if (erase_all_en) begin
      for (int r = 0; r < NUM_ROWS; r++) mem[r] <= '1;
    end else if (erase_page_en) begin
      for (int r = 0; r < NUM_ROWS; r++)
        if ((r / ROWS_PER_PAGE) == int'(page_sel)) mem[r] <= '1;
    end else if (prog_en) begin
      mem[row_sel] <= new_row;
    end
  end

  // R4: a program never sets a bit that was clear
  a_r4_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> ((mem[$past(row_sel)] & ~$past(cur_row)) == '0));

  // R7: a whole-array erase leaves first and last rows blank
  a_r7_mass_blank: assert property (@(posedge clk) disable iff (!rst_n)
    erase_all_en |=> ((mem[0] == '1) && (mem[NUM_ROWS-1] == '1)));

endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import flash_pgm_pkg::*;
#(
  parameter int NUM_PAGES  = 2,
  parameter int PAGE_BYTES = 4096,
  parameter int ROW_BYTES  = 32,
  parameter int SETUP_CYC  = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    addr_wr,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0] addr_wdata,
  input  logic                                    idx_wr,
  input  logic [$clog2(ROW_BYTES):0]              idx_wdata,
  input  logic                                    data_wr,
  input  logic [7:0]                              data_wdata,
  input  logic [2:0]                              tim_wr_sel,
  input  logic [31:0]                             tim_wdata,
  input  logic                                    cmd_wr,
  input  logic [2:0]                              cmd_wdata,
  output logic                                    busy,
  output logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0] addr_q,
  output logic [$clog2(ROW_BYTES):0]              idx_q,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0] rd_addr,
  output logic [7:0]                              rd_data
);
  localparam int ADDR_W   = $clog2(NUM_PAGES * PAGE_BYTES);
  localparam int LANE_W   = $clog2(ROW_BYTES);
  localparam int PG_SHIFT = $clog2(PAGE_BYTES);
  localparam int PAGE_W   = $clog2(NUM_PAGES);
  localparam int ROW_W    = ADDR_W - LANE_W;
  localparam int CNT_W    = 24;

  logic [15:0] t_hold_q;
  logic [23:0] t_erase_q;
  logic [15:0] t_prog_q;
  op_e         op_q, cmd_op;
  logic        start, main_done, op_done;
  logic [CNT_W-1:0] main_len, hold_len;
  logic [ROW_BYTES*8-1:0] row_data;
  logic [ROW_BYTES-1:0]   row_mask;
  logic        data_taken;

  assign cmd_op = decode_cmd(cmd_wdata);
  assign start  = cmd_wr && !busy && (cmd_op != OP_NONE);

  // Timing fields and pending operation; all writes gated by busy.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_hold_q  <= '0;
      t_erase_q <= '0;
      t_prog_q  <= '0;
      op_q      <= OP_NONE;
      addr_q    <= '0;
    end else begin
      if (!busy) begin
        if (tim_wr_sel[0]) t_hold_q  <= tim_wdata[31:16];
        if (tim_wr_sel[1]) t_erase_q <= tim_wdata[23:0];
        if (tim_wr_sel[2]) t_prog_q  <= tim_wdata[15:0];
        if (addr_wr)       addr_q    <= addr_wdata;
      end
      if (start) op_q <= cmd_op;
      if (op_done && op_q == OP_PROG) addr_q <= addr_q + ADDR_W'(idx_q);
    end
  end

  assign main_len = (op_q == OP_PROG) ? phase_len({8'd0, t_prog_q}) : phase_len(t_erase_q);
  assign hold_len = phase_len({8'd0, t_hold_q});

  pgm_buffer #(.ROW_BYTES(ROW_BYTES)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_we    (data_wr && !busy),
    .data_in    (data_wdata),
    .idx_we     (idx_wr && !busy),
    .idx_in     (idx_wdata),
    .row_off    (addr_q[LANE_W-1:0]),
    .idx_q      (idx_q),
    .row_data   (row_data),
    .row_mask   (row_mask),
    .data_taken (data_taken)
  );

  op_sequencer #(.CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .main_len  (main_len),
    .hold_len  (hold_len),
    .busy      (busy),
    .main_done (main_done),
    .op_done   (op_done)
  );

  nvm_array_model #(
    .NUM_PAGES (NUM_PAGES),
    .PAGE_BYTES(PAGE_BYTES),
    .ROW_BYTES (ROW_BYTES)
  ) u_array (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_en       (main_done && op_q == OP_PROG),
    .erase_page_en (main_done && op_q == OP_PAGE_ERASE),
    .erase_all_en  (main_done && op_q == OP_MASS_ERASE),
    .row_sel       (addr_q[ADDR_W-1:LANE_W]),
    .page_sel      (addr_q[ADDR_W-1:PG_SHIFT]),
    .prog_data     (row_data),
    .prog_mask     (row_mask),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data)
  );

  // R5: a finished program moves the address by the fill index
  a_r5_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_q == OP_PROG) |=> (addr_q == $past(addr_q) + ADDR_W'($past(idx_q))));

  // R5: a finished erase keeps the address
  a_r5_erase_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && op_q != OP_PROG) |=> $stable(addr_q));

  // R8: a command arriving during busy does not replace the operation
  a_r8_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(op_q));

  // R8: buffer data is never taken during an operation
  a_r8_no_fill_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !data_taken);

endmodule

// File: tb/tb_flash_pgm_seq.sv
module tb_flash_pgm_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr = 0, idx_wr = 0, data_wr = 0, cmd_wr = 0;
  logic [12:0] addr_wdata = '0, rd_addr = '0, addr_q;
  logic [5:0]  idx_wdata = '0, idx_q;
  logic [7:0]  data_wdata = '0, rd_data;
  logic [2:0]  tim_wr_sel = '0, cmd_wdata = '0;
  logic [31:0] tim_wdata = '0;
  logic        busy;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_pgm_seq dut (
    .clk(clk), .rst_n(rst_n),
    .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .idx_wr(idx_wr), .idx_wdata(idx_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata),
    .tim_wr_sel(tim_wr_sel), .tim_wdata(tim_wdata),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .busy(busy), .addr_q(addr_q), .idx_q(idx_q),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [12:0] a);
    @(negedge clk); addr_wr = 1; addr_wdata = a;
    @(negedge clk); addr_wr = 0;
  endtask

  task automatic set_idx(input logic [5:0] v);
    @(negedge clk); idx_wr = 1; idx_wdata = v;
    @(negedge clk); idx_wr = 0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); data_wr = 1; data_wdata = d;
    @(negedge clk); data_wr = 0;
  endtask

  task automatic set_tim(input logic [2:0] sel, input logic [31:0] v);
    @(negedge clk); tim_wr_sel = sel; tim_wdata = v;
    @(negedge clk); tim_wr_sel = '0;
  endtask

  task automatic rd_chk(input string req, input logic [12:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  // Issue a command and count busy cycles.
  task automatic run_cmd(input string req, input logic [2:0] c, input int exp_len);
    int n = 0;
    @(negedge clk); cmd_wr = 1; cmd_wdata = c;
    forever begin
      @(negedge clk); cmd_wr = 0;
      if (busy) n++; else break;
      if (n > 5000) break;
    end
    chk(req, n, exp_len);
  endtask

  task automatic t_reset;
    chk("R9 busy", busy, 0);
    chk("R9 addr", addr_q, 0);
    chk("R9 idx", idx_q, 0);
    rd_chk("R9 array first", 13'h0000, 8'hFF);
    rd_chk("R9 array last", 13'h1FFF, 8'hFF);
  endtask

  task automatic t_zero_timing;
    run_cmd("R6 zero timing length", 3'b001, 4);
    chk("R5 empty program keeps addr", addr_q, 0);
    @(negedge clk); cmd_wr = 1; cmd_wdata = 3'b000;
    @(negedge clk); cmd_wr = 0;
    chk("R7 null command no busy", busy, 0);
  endtask

  task automatic t_program;
    set_addr(13'h010); set_idx(0);
    push(8'hA5); push(8'h3C); push(8'h0F); push(8'h81);
    chk("R1 index after four bytes", idx_q, 4);
    run_cmd("R6 program length", 3'b001, 10);
    rd_chk("R4 byte 0x10", 13'h010, 8'hA5);
    rd_chk("R4 byte 0x13", 13'h013, 8'h81);
    rd_chk("R4 below range untouched", 13'h00F, 8'hFF);
    rd_chk("R4 above range untouched", 13'h014, 8'hFF);
    chk("R5 address advanced", addr_q, 13'h014);
  endtask

  task automatic t_clear_only;
    set_addr(13'h010); set_idx(0); push(8'hF0);
    run_cmd("R6 program length 2", 3'b001, 10);
    rd_chk("R4 and with old", 13'h010, 8'hA0);
    set_addr(13'h012); set_idx(0); push(8'hFF);
    run_cmd("R6 program length 3", 3'b001, 10);
    rd_chk("R4 cannot set bits", 13'h012, 8'h0F);
  endtask

  task automatic t_boundary;
    set_addr(13'h01E); set_idx(0);
    push(8'h11); push(8'h22); push(8'h33);
    chk("R3 index stops at row end", idx_q, 2);
    run_cmd("R6 program length 4", 3'b001, 10);
    rd_chk("R3 lane 30", 13'h01E, 8'h11);
    rd_chk("R3 lane 31", 13'h01F, 8'h22);
    rd_chk("R3 next row untouched", 13'h020, 8'hFF);
    chk("R5 address to next row", addr_q, 13'h020);
  endtask

  task automatic t_index_load;
    set_idx(6'd3);
    chk("R2 index load", idx_q, 3);
    set_idx(6'd0);
    chk("R2 index clear", idx_q, 0);
  endtask

  task automatic t_page_erase;
    set_addr(13'h1005); set_idx(0); push(8'h5A);
    run_cmd("R6 program length 5", 3'b001, 10);
    rd_chk("R4 page1 byte", 13'h1005, 8'h5A);
    set_addr(13'h1000);
    run_cmd("R6 erase length", 3'b110, 12);
    rd_chk("R7 page1 erased", 13'h1005, 8'hFF);
    rd_chk("R7 page0 kept", 13'h01F, 8'h22);
    chk("R5 erase keeps addr", addr_q, 13'h1000);
  endtask

  task automatic t_busy_ignore;
    int n = 0;
    logic [5:0] idx_before;
    idx_before = idx_q;
    @(negedge clk); cmd_wr = 1; cmd_wdata = 3'b110;
    @(negedge clk); cmd_wr = 0;
    if (busy) n++;
    addr_wr = 1; addr_wdata = 13'h0040;
    idx_wr = 1; idx_wdata = 6'd7;
    data_wr = 1; data_wdata = 8'h00;
    tim_wr_sel = 3'b100; tim_wdata = 32'd1;
    cmd_wr = 1; cmd_wdata = 3'b001;
    forever begin
      @(negedge clk);
      addr_wr = 0; idx_wr = 0; data_wr = 0; tim_wr_sel = '0; cmd_wr = 0;
      if (busy) n++; else break;
      if (n > 5000) break;
    end
    chk("R8 no second operation", n, 12);
    chk("R8 address write dropped", addr_q, 13'h1000);
    chk("R8 index write dropped", idx_q, idx_before);
    set_addr(13'h0100); set_idx(0);
    run_cmd("R8 timing write dropped", 3'b001, 10);
  endtask

  task automatic t_mass_erase;
    set_addr(13'h0000);
    run_cmd("R6 mass erase length", 3'b010, 12);
    rd_chk("R7 mass erase row0", 13'h010, 8'hFF);
    rd_chk("R7 mass erase lane31", 13'h01F, 8'hFF);
    set_addr(13'h0020); set_idx(0); push(8'h12);
    run_cmd("R7 erase outranks program", 3'b011, 12);
    rd_chk("R7 erase won", 13'h020, 8'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_timing();
    set_tim(3'b001, 32'h0003_0000);
    set_tim(3'b010, 32'd7);
    set_tim(3'b100, 32'd5);
    t_program();
    t_clear_only();
    t_boundary();
    t_index_load();
    t_page_erase();
    t_busy_ignore();
    t_mass_erase();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule